// File: doc/BRIEF.md
# SDRAM Column Burst Sequencer with Latency Pipeline

This block sits between a memory controller's command decoder and the data path of a synchronous DRAM column interface. Each accepted read or write column command loads a starting column, an ordering (sequential or interleaved), and a burst-length code. The block then emits one column address per clock until the burst ends. A new column command or a precharge cuts the current burst short.

For reads, a strobe marks the cycle in which the data word for each beat is valid. The strobe is delayed by the programmed CAS latency of 1 to 3 clocks. A data-mask input is applied at two different lags. For a write, the mask acts on the beat issued at the same edge. For a read, it acts on the data word sampled two edges after the mask was seen.

A full-page burst in sequential order covers every column of the row and wraps from the top column back to zero. It runs until another command or a precharge arrives. After a precharge, read beats already in the latency pipeline still drain. No new beats start.

Top module: `sdram_bseq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `col_valid`, `col_write`, `rd_valid`, `rd_mask` and `wr_mask` are all 0.
- R2: With `burst_order`=0 (sequential) and a burst length N of 2, 4 or 8, beat i has these properties. Its low log2(N) bits equal (start + i) mod N. Its upper bits equal those of the start column.
- R3: With `burst_order`=1 (interleaved) and N of 2, 4 or 8, beat i has these properties. Its low log2(N) bits equal the start column's low bits XOR i. Its upper bits are unchanged.
- R4: `burst_len` encodes the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page. Codes 4 to 6, and code 7 together with interleaved order, give a single beat. `col_valid` is high for exactly that many consecutive cycles.
- R5: A full-page burst (code 7, sequential) increments the column by one every cycle and wraps from 511 to 0. It never ends by itself.
- R6: When `cmd_valid` is high without `precharge`, the next cycle shows `col_valid`=1 and `col_addr`=`cmd_col`. Any burst in progress is abandoned.
- R7: Suppose a read beat is shown on `col_addr` in the cycle following edge e. Then `rd_valid` is high in the cycle following edge e + L - 1, so the data is sampled at edge e + L. Here L is `cas_lat` (1 to 3, with 0 treated as 1).
- R8: `rd_mask` is high exactly when `rd_valid` is high and `dqm` was high at the edge two edges before the sampling edge of that read word.
- R9: `wr_mask` is high exactly when the shown beat is a write and `dqm` was high at the edge that issued it. Write beats never raise `rd_valid`.
- R10: `precharge` (which takes priority over `cmd_valid`) drops `col_valid` from the next cycle on. Read beats issued before it still produce their `rd_valid` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Column command (read or write) this edge |
| cmd_write | input | 1 | 1 = write command, 0 = read |
| cmd_col | input | 9 | Starting column of the burst |
| burst_order | input | 1 | 0 = sequential, 1 = interleaved |
| burst_len | input | 3 | Burst-length code (see R4) |
| cas_lat | input | 2 | Read latency in clocks, 1 to 3 |
| precharge | input | 1 | Precharge command, ends the burst |
| dqm | input | 1 | Data mask input |
| col_valid | output | 1 | A burst beat is shown this cycle |
| col_write | output | 1 | The shown beat belongs to a write |
| col_addr | output | 9 | Column of the shown beat |
| rd_valid | output | 1 | Read data word valid this cycle |
| rd_mask | output | 1 | The current read word is masked |
| wr_mask | output | 1 | The shown write beat is masked |

## Verification
The assertions check several rules on every cycle. A new command shows its start column on the next cycle. Precharge stops the beats. Full-page bursts step by one with a 9-bit wrap. Both masks follow the delayed mask input. A latency-2 read strobe tracks the read beats of the previous cycle. Beat counts for each length code, the sequential wrap inside a block, the XOR order, reserved codes, and draining after a precharge can only be shown by the bench's scenarios. There, a behavioural model predicts every output on every clock.

// File: rtl/sdram_bseq_pkg.sv
package sdram_bseq_pkg;

   // Burst-length codes; values not listed act as a single beat.
   typedef enum logic [2:0] {
      BL_ONE   = 3'd0,
      BL_TWO   = 3'd1,
      BL_FOUR  = 3'd2,
      BL_EIGHT = 3'd3,
      BL_PAGE  = 3'd7
   } blen_e;

   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_XOR = 1'b1
   } order_e;

   localparam int MIN_COL_W = 4;

endpackage

// File: rtl/sdram_bseq_ctl.sv
module sdram_bseq_ctl
   import sdram_bseq_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_write,
   input  logic [COL_W-1:0] cmd_col,
   input  order_e           cmd_order,
   input  blen_e            cmd_len,
   input  logic             precharge,
   output logic             act_q,
   output logic             wr_q,
   output order_e           ord_q,
   output logic             full_q,
   output logic [COL_W-1:0] start_q,
   output logic [COL_W-1:0] idx_q,
   output logic [COL_W-1:0] mask_q
);

   logic [COL_W-1:0] len_mask;
   logic             len_full;

   // Length code to in-block offset mask; full page only in sequential order.
   always_comb begin
      len_full = 1'b0;
      unique case (cmd_len)
         BL_TWO:   len_mask = COL_W'(1);
         BL_FOUR:  len_mask = COL_W'(3);
         BL_EIGHT: len_mask = COL_W'(7);
         BL_PAGE: begin
            len_full = (cmd_order == ORD_SEQ);
            len_mask = len_full ? {COL_W{1'b1}} : '0;
         end
         default:  len_mask = '0;
      endcase
   end

   logic beat_done;
   assign beat_done = !full_q && (idx_q == mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         wr_q    <= 1'b0;
         ord_q   <= ORD_SEQ;
         full_q  <= 1'b0;
         start_q <= '0;
         idx_q   <= '0;
         mask_q  <= '0;
      end else if (precharge) begin
         act_q <= 1'b0;
      end else if (cmd_valid) begin
         act_q   <= 1'b1;
         wr_q    <= cmd_write;
         ord_q   <= cmd_order;
         full_q  <= len_full;
         start_q <= cmd_col;
         idx_q   <= '0;
         mask_q  <= len_mask;
      end else if (act_q) begin
         if (beat_done) begin
            act_q <= 1'b0;
         end else begin
            idx_q <= idx_q + COL_W'(1);
         end
      end
   end

endmodule

// File: rtl/sdram_bseq_colgen.sv
module sdram_bseq_colgen
   import sdram_bseq_pkg::*;
#(
   parameter int COL_W         = 9,
   parameter bit INTERLEAVE_EN = 1'b1
) (
   input  logic [COL_W-1:0] start,
   input  logic [COL_W-1:0] idx,
   input  logic [COL_W-1:0] mask,
   input  order_e           order,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] stepped;

   generate
      if (INTERLEAVE_EN) begin : g_both
         always_comb begin
            if (order == ORD_XOR) stepped = start ^ idx;
            else                  stepped = start + idx;
         end
      end else begin : g_seq_only
         logic unused_order;
         assign unused_order = order;
         assign stepped      = start + idx;
      end
   endgenerate

   // Upper bits from the start column, low bits from the stepped value.
   assign col = (start & ~mask) | (stepped & mask);

endmodule

// File: rtl/sdram_bseq_latpipe.sv
module sdram_bseq_latpipe #(
   parameter int MAX_CL      = 3,
   parameter int RD_MASK_LAG = 2,
   parameter int CLW         = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           rd_beat,
   input  logic           wr_beat,
   input  logic           dqm,
   input  logic [CLW-1:0] cas_lat,
   output logic           rd_valid,
   output logic           rd_mask,
   output logic           wr_mask
);

   logic [MAX_CL-1:0]      tap;
   logic [RD_MASK_LAG-1:0] dqm_sr;

   assign tap[0] = rd_beat;

   genvar k;
   generate
      for (k = 1; k < MAX_CL; k++) begin : g_stg
         logic q;
         if (k == 1) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) q <= 1'b0;
               else        q <= rd_beat;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) q <= 1'b0;
               else        q <= g_stg[k-1].q;
         end
         assign tap[k] = q;
      end

      if (RD_MASK_LAG == 1) begin : g_lag1
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) dqm_sr <= '0;
            else        dqm_sr <= dqm;
      end else begin : g_lagn
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) dqm_sr <= '0;
            else        dqm_sr <= {dqm_sr[RD_MASK_LAG-2:0], dqm};
      end
   endgenerate

   // Latency selects a tap; 0 or out-of-range values act as latency 1.
   always_comb begin
      rd_valid = tap[0];
      for (int s = 1; s < MAX_CL; s++) begin
         if (int'(cas_lat) == s + 1) rd_valid = tap[s];
      end
   end

   assign rd_mask = rd_valid & dqm_sr[RD_MASK_LAG-1];
   assign wr_mask = wr_beat & dqm_sr[0];

endmodule

// File: rtl/sdram_bseq.sv
module sdram_bseq
   import sdram_bseq_pkg::*;
#(
   parameter int COL_W         = 9,
   parameter int MAX_CL        = 3,
   parameter int RD_MASK_LAG   = 2,
   parameter bit INTERLEAVE_EN = 1'b1,
   parameter int CLW           = $clog2(MAX_CL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_write,
   input  logic [COL_W-1:0] cmd_col,
   input  logic             burst_order,
   input  logic [2:0]       burst_len,
   input  logic [CLW-1:0]   cas_lat,
   input  logic             precharge,
   input  logic             dqm,
   output logic             col_valid,
   output logic             col_write,
   output logic [COL_W-1:0] col_addr,
   output logic             rd_valid,
   output logic             rd_mask,
   output logic             wr_mask
);

   generate
      if (COL_W < MIN_COL_W) begin : g_bad_colw
         $error("sdram_bseq: COL_W too small");
      end
      if (MAX_CL < 2) begin : g_bad_cl
         $error("sdram_bseq: MAX_CL must be at least 2");
      end
      if (RD_MASK_LAG < 1) begin : g_bad_lag
         $error("sdram_bseq: RD_MASK_LAG must be at least 1");
      end
   endgenerate

   logic             act_q, wr_q, burst_full;
   order_e           ord_q;
   logic [COL_W-1:0] start_q, idx_q, mask_q;

   sdram_bseq_ctl #(.COL_W(COL_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_write (cmd_write),
      .cmd_col   (cmd_col),
      .cmd_order (order_e'(burst_order)),
      .cmd_len   (blen_e'(burst_len)),
      .precharge (precharge),
      .act_q     (act_q),
      .wr_q      (wr_q),
      .ord_q     (ord_q),
      .full_q    (burst_full),
      .start_q   (start_q),
      .idx_q     (idx_q),
      .mask_q    (mask_q)
   );

   sdram_bseq_colgen #(.COL_W(COL_W), .INTERLEAVE_EN(INTERLEAVE_EN)) u_col (
      .start (start_q),
      .idx   (idx_q),
      .mask  (mask_q),
      .order (ord_q),
      .col   (col_addr)
   );

   sdram_bseq_latpipe #(.MAX_CL(MAX_CL), .RD_MASK_LAG(RD_MASK_LAG), .CLW(CLW)) u_lat (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_beat  (act_q & ~wr_q),
      .wr_beat  (act_q & wr_q),
      .dqm      (dqm),
      .cas_lat  (cas_lat),
      .rd_valid (rd_valid),
      .rd_mask  (rd_mask),
      .wr_mask  (wr_mask)
   );

   assign col_valid = act_q;
   assign col_write = act_q & wr_q;

endmodule

// File: rtl/sdram_bseq_chk.sv
module sdram_bseq_chk #(
   parameter int COL_W = 9,
   parameter int CLW   = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [COL_W-1:0] cmd_col,
   input logic             precharge,
   input logic             dqm,
   input logic [CLW-1:0]   cas_lat,
   input logic             col_valid,
   input logic             col_write,
   input logic [COL_W-1:0] col_addr,
   input logic             rd_valid,
   input logic             rd_mask,
   input logic             wr_mask,
   input logic             burst_full
);

   // R1: outputs quiet while reset is held
   always_comb begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (!col_valid && !col_write && !rd_valid && !rd_mask && !wr_mask);
      end
   end

   p_cmd_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !precharge) |=> (col_valid && col_addr == $past(cmd_col)));

   p_pre_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      precharge |=> !col_valid);

   p_page_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && burst_full && !cmd_valid && !precharge)
      |=> (col_valid && col_addr == $past(col_addr) + COL_W'(1)));

   p_rd_mask_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_mask |-> (rd_valid && $past(dqm, 2)));

   p_wr_mask_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask |-> (col_valid && col_write && $past(dqm)));

   p_wr_no_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && col_write && cas_lat <= CLW'(1)) |-> !rd_valid);

   p_rd_cl2_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cas_lat) == CLW'(2) && cas_lat == CLW'(2))
      |-> (rd_valid == $past(col_valid && !col_write)));

endmodule

bind sdram_bseq sdram_bseq_chk #(.COL_W(COL_W), .CLW(CLW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_col    (cmd_col),
   .precharge  (precharge),
   .dqm        (dqm),
   .cas_lat    (cas_lat),
   .col_valid  (col_valid),
   .col_write  (col_write),
   .col_addr   (col_addr),
   .rd_valid   (rd_valid),
   .rd_mask    (rd_mask),
   .wr_mask    (wr_mask),
   .burst_full (burst_full)
);

// File: tb/sdram_bseq_tb.sv
`timescale 1ns/1ps
module sdram_bseq_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0, cmd_write = 1'b0;
   logic [8:0] cmd_col = '0;
   logic       burst_order = 1'b0;
   logic [2:0] burst_len = 3'd0;
   logic [1:0] cas_lat = 2'd1;
   logic       precharge = 1'b0, dqm = 1'b0;
   logic       col_valid, col_write, rd_valid, rd_mask, wr_mask;
   logic [8:0] col_addr;

   always #2.5 clk = ~clk;

   sdram_bseq dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_col(cmd_col), .burst_order(burst_order), .burst_len(burst_len),
      .cas_lat(cas_lat), .precharge(precharge), .dqm(dqm),
      .col_valid(col_valid), .col_write(col_write), .col_addr(col_addr),
      .rd_valid(rd_valid), .rd_mask(rd_mask), .wr_mask(wr_mask)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   string tag = "R1";
   bit    finished = 1'b0;

   // Behavioural reference model
   bit m_act = 0, m_wr = 0, m_il = 0, m_full = 0;
   int m_start = 0, m_idx = 0, m_len = 1, m_n = 0;
   bit rb[8];
   bit dq[8];

   function automatic int len_of(input int code, input bit il);
      case (code)
         0: return 1;
         1: return 2;
         2: return 4;
         3: return 8;
         7: return il ? 1 : 512;
         default: return 1;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_wr = 0; m_n = 0; m_idx = 0;
         for (int i = 0; i < 8; i++) begin rb[i] = 0; dq[i] = 0; end
      end else begin
         if (precharge) m_act = 0;
         else if (cmd_valid) begin
            m_act = 1; m_wr = cmd_write; m_il = burst_order;
            m_start = int'(cmd_col); m_idx = 0;
            m_len = len_of(int'(burst_len), burst_order);
            m_full = (m_len == 512);
         end else if (m_act) begin
            if (!m_full && m_idx == m_len - 1) m_act = 0;
            else m_idx = (m_idx + 1) % 512;
         end
         m_n = m_n + 1;
         dq[m_n % 8] = dqm;
         rb[m_n % 8] = m_act && !m_wr;
      end
   end

   function automatic int exp_col();
      int base, off;
      if (m_full) return (m_start + m_idx) % 512;
      off  = m_start % m_len;
      base = m_start - off;
      if (m_il) return base + (off ^ m_idx);
      return base + ((off + m_idx) % m_len);
   endfunction

   task automatic chk(input string what, input int got, input int exp);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d (t=%0t)", tag, what, got, exp, $time);
      end
   endtask

   task automatic compare();
      int  cl;
      bit  e_rv;
      cl   = (cas_lat == 0) ? 1 : int'(cas_lat);
      e_rv = rb[(m_n - cl + 1 + 8) % 8];
      chk("col_valid", col_valid, m_act);
      chk("col_write", col_write, m_act && m_wr);
      if (m_act) chk("col_addr", col_addr, exp_col());
      chk("rd_valid", rd_valid, e_rv);
      chk("rd_mask", rd_mask, e_rv && dq[(m_n - 1 + 8) % 8]);
      chk("wr_mask", wr_mask, m_act && m_wr && dq[m_n % 8]);
   endtask

   // Compare at the falling edge, then drive the next inputs.
   task automatic tick(input bit cv, input bit wr, input int c, input bit il,
                       input int bl, input bit pre, input bit dm);
      @(negedge clk);
      compare();
      cmd_valid = cv; cmd_write = wr; cmd_col = 9'(c); burst_order = il;
      burst_len = 3'(bl); precharge = pre; dqm = dm;
   endtask

   task automatic idle(input int cycles);
      for (int i = 0; i < cycles; i++) tick(0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      tag = "R1";
      idle(3);
      @(negedge clk); rst_n = 1'b1;
      idle(2);

      // R2: sequential BL4 read from 13 -> 13,14,15,12 at latency 2
      tag = "R2"; cas_lat = 2'd2;
      tick(1, 0, 13, 0, 2, 0, 0);
      idle(7);
      tick(1, 0, 'h1FB, 0, 3, 0, 0);   // BL8 from 0x1FB wraps in its block of 8
      idle(10);

      // R3: interleaved BL8 from 0x15 -> low bits 5,4,7,6,1,0,3,2
      tag = "R3";
      tick(1, 0, 'h15, 1, 3, 0, 0);
      idle(10);
      tick(1, 1, 'h0A, 1, 2, 0, 0);
      idle(6);

      // R4: lengths 1 and 2, reserved codes, page code with XOR order
      tag = "R4";
      tick(1, 0, 40, 0, 0, 0, 0);
      idle(4);
      tick(1, 0, 41, 0, 1, 0, 0);
      idle(4);
      tick(1, 0, 77, 0, 5, 0, 0);
      idle(4);
      tick(1, 0, 78, 1, 7, 0, 0);
      idle(4);

      // R5: full page from 509 wraps through 0 and keeps going
      tag = "R5";
      tick(1, 0, 509, 0, 7, 0, 0);
      idle(520);

      // R6: new commands interrupt, issued every cycle
      tag = "R6";
      tick(1, 0, 100, 0, 3, 0, 0);
      tick(1, 1, 200, 1, 3, 0, 0);
      tick(1, 0, 300, 0, 2, 0, 0);
      tick(1, 1, 17, 0, 1, 0, 0);
      idle(12);

      // R7: latency 1 and 3 reads
      tag = "R7"; cas_lat = 2'd1;
      tick(1, 0, 64, 0, 2, 0, 0);
      idle(8);
      cas_lat = 2'd3;
      tick(1, 0, 64, 1, 2, 0, 0);
      idle(8);

      // R8: read mask two edges later, with toggling mask
      tag = "R8";
      for (int l = 1; l <= 3; l++) begin
         cas_lat = 2'(l);
         tick(1, 0, 8 * l, 0, 3, 0, 0);
         for (int i = 0; i < 11; i++) tick(0, 0, 0, 0, 0, 0, (i % 3) == 1);
      end

      // R9: write mask same edge; writes never strobe read data
      tag = "R9"; cas_lat = 2'd2;
      tick(1, 1, 90, 0, 3, 0, 1);
      for (int i = 0; i < 9; i++) tick(0, 0, 0, 0, 0, 0, i[0]);
      cas_lat = 2'd1;
      tick(1, 1, 91, 1, 2, 0, 0);
      idle(6);

      // R10: precharge mid read burst, pipeline drains
      tag = "R10"; cas_lat = 2'd3;
      tick(1, 0, 150, 0, 3, 0, 0);
      idle(3);
      tick(0, 0, 0, 0, 0, 1, 0);
      idle(6);
      tick(1, 0, 5, 0, 7, 0, 0);
      idle(4);
      tick(1, 0, 9, 0, 3, 1, 0);     // precharge wins over command
      idle(6);

      idle(2);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule